// File: doc/BRIEF.md
# Operate Microinstruction Executor

This block carries out the operate class of instructions for a 12-bit accumulator machine. One instruction word may hold several micro-operations. In the first operate group these are accumulator and link updates, applied in a fixed order. In the second group the word holds a three-bit code that selects one of eight tests on the accumulator, and a passing test makes the program counter step over one extra word.

The sequencer supplies the instruction word, the current accumulator, the link bit and the address of the instruction, and raises `exec_en` for one cycle. The next state is worked out combinationally and captured on that clock edge. In the following cycle the block presents the new accumulator, the new link, the skip decision and the next program counter, and marks them with `res_valid`.

Instruction bit numbering below uses vector indices, so bit 11 is the most significant bit of the word.

Top module: `opx_exec`

## Requirements
- R1: While `rst_n` is low, `ac_out`, `link_out`, `skip_out`, `pc_out` and `res_valid` are all zero.
- R2: `res_valid` is high exactly in the cycle after a cycle with `exec_en` high. When `exec_en` is low, all result outputs keep their values.
- R3: When `instr[11:9]` is not 3'b111, the instruction is not an operate instruction. AC and link pass through unchanged, no skip is taken, and `pc_out` = `pc_in` + 1.
- R4: In group 1 (`instr[11:9]`=3'b111 and `instr[8]`=0), `instr[6]` clears the link and `instr[4]` complements it. With both bits set, the link ends at 1.
- R5: In group 1, `instr[7]` clears AC and `instr[5]` complements AC. Clearing comes before complementing, so with both bits set AC becomes all ones.
- R6: In group 1, `instr[0]` adds one to AC after the clear and complement steps. A carry out of the top AC bit complements the link after the link's own clear and complement steps.
- R7: A group 1 instruction never skips.
- R8: In group 2 (`instr[11:9]`=3'b111 and `instr[8]`=1), AC and link pass through unchanged. All bits other than the group and code bits are ignored.
- R9: In group 2 the skip code is {`instr[6]`,`instr[5]`,`instr[3]`}. Its values mean: 0 never, 1 always, 2 AC=0, 3 AC≠0, 4 AC<0, 5 AC>0, 6 AC≤0, 7 AC≥0.
- R10: AC is two's complement. AC is negative exactly when its most significant bit is 1, so 0x800 is less than 0 and 0x7FF is greater than 0.
- R11: `pc_out` is `pc_in` + 2 when the skip is taken and `pc_in` + 1 otherwise, both modulo 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute the presented instruction this cycle |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| pc_in | input | 12 | Address of the instruction |
| ac_out | output | 12 | Accumulator after execution |
| link_out | output | 1 | Link after execution |
| skip_out | output | 1 | Skip taken |
| pc_out | output | 12 | Address of the next instruction |
| res_valid | output | 1 | Results updated by the previous cycle |

## Verification
A wrongly ordered micro-operation shows up as a wrong `ac_out` or `link_out` in the cycle right after `exec_en`. Examples are a complement applied before a clear, or an increment carry lost before it reaches the link. A misrouted skip code bit or a wrong sign test shows up in that same cycle as a wrong `skip_out` and a `pc_out` that is off by one word. The vector table pairs each test code with accumulator values on both sides of its boundary (zero, 0x7FF, 0x800, 0xFFF), so any single wrong entry in the condition table flips an observed skip.

// File: rtl/opx_pkg.sv
package opx_pkg;
   localparam int INSTR_W = 12;

   // bit positions inside the instruction word (vector indices)
   localparam int OP_HI    = 11;
   localparam int OP_LO    = 9;
   localparam int GRP_BIT  = 8;
   localparam int CLRA_BIT = 7;
   localparam int CLRL_BIT = 6;
   localparam int CMPA_BIT = 5;
   localparam int CMPL_BIT = 4;
   localparam int INCA_BIT = 0;
   localparam int SKC2_BIT = 6;
   localparam int SKC1_BIT = 5;
   localparam int SKC0_BIT = 3;

   localparam logic [OP_HI-OP_LO:0] OPR_OPCODE = '1;

   typedef enum logic [2:0] {
      SK_NEVER = 3'd0,
      SK_ALWAYS = 3'd1,
      SK_ZERO = 3'd2,
      SK_NONZERO = 3'd3,
      SK_NEG = 3'd4,
      SK_POS = 3'd5,
      SK_NONPOS = 3'd6,
      SK_NONNEG = 3'd7
   } skip_code_t;

   typedef struct packed {
      logic       is_opr;
      logic       grp2;
      logic       clr_ac;
      logic       clr_lk;
      logic       cmp_ac;
      logic       cmp_lk;
      logic       inc_ac;
      skip_code_t code;
   } opx_ctl_t;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
   import opx_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output opx_ctl_t           ctl
);
   always_comb begin
      ctl.is_opr = (instr[OP_HI:OP_LO] == OPR_OPCODE);
      ctl.grp2   = instr[GRP_BIT];
      ctl.clr_ac = instr[CLRA_BIT];
      ctl.clr_lk = instr[CLRL_BIT];
      ctl.cmp_ac = instr[CMPA_BIT];
      ctl.cmp_lk = instr[CMPL_BIT];
      ctl.inc_ac = instr[INCA_BIT];
      ctl.code   = skip_code_t'({instr[SKC2_BIT], instr[SKC1_BIT], instr[SKC0_BIT]});
   end
endmodule

// File: rtl/opx_group1.sv
module opx_group1 #(
   parameter int DATA_W = 12
) (
   input  logic              clr_ac,
   input  logic              clr_lk,
   input  logic              cmp_ac,
   input  logic              cmp_lk,
   input  logic              inc_ac,
   input  logic [DATA_W-1:0] ac_i,
   input  logic              lk_i,
   output logic [DATA_W-1:0] ac_o,
   output logic              lk_o
);
   localparam int SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] ac_clr, ac_cmp;
   logic              lk_clr, lk_cmp;
   logic [SUM_W-1:0]  sum;

   // stage 1: clears
   assign ac_clr = clr_ac ? '0 : ac_i;
   assign lk_clr = clr_lk ? 1'b0 : lk_i;
   // stage 2: complements
   assign ac_cmp = cmp_ac ? ~ac_clr : ac_clr;
   assign lk_cmp = cmp_lk ? ~lk_clr : lk_clr;
   // stage 3: increment, carry flips the link
   assign sum  = {1'b0, ac_cmp} + SUM_W'(inc_ac);
   assign ac_o = sum[DATA_W-1:0];
   assign lk_o = lk_cmp ^ sum[DATA_W];
endmodule

// File: rtl/opx_skip.sv
module opx_skip
   import opx_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int STYLE  = 0
) (
   input  skip_code_t        code,
   input  logic [DATA_W-1:0] ac,
   output logic              take
);
   logic neg, zero;
   assign neg  = ac[DATA_W-1];
   assign zero = (ac == '0);

   generate
      if (STYLE == 0) begin : g_case
         always_comb begin
            unique case (code)
               SK_NEVER:   take = 1'b0;
               SK_ALWAYS:  take = 1'b1;
               SK_ZERO:    take = zero;
               SK_NONZERO: take = ~zero;
               SK_NEG:     take = neg;
               SK_POS:     take = ~neg & ~zero;
               SK_NONPOS:  take = neg | zero;
               SK_NONNEG:  take = ~neg;
               default:    take = 1'b0;
            endcase
         end
      end else begin : g_vector
         logic [7:0] cond_vec;
         assign cond_vec = {~neg, neg | zero, ~neg & ~zero, neg,
                            ~zero, zero, 1'b1, 1'b0};
         assign take = cond_vec[code];
      end
   endgenerate
endmodule

// File: rtl/opx_exec.sv
module opx_exec
   import opx_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int ADDR_W     = 12,
   parameter int SKIP_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  ac_in,
   input  logic               link_in,
   input  logic [ADDR_W-1:0]  pc_in,
   output logic [DATA_W-1:0]  ac_out,
   output logic               link_out,
   output logic               skip_out,
   output logic [ADDR_W-1:0]  pc_out,
   output logic               res_valid
);
   localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PC_TWO = ADDR_W'(2);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("opx_exec: DATA_W must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("opx_exec: ADDR_W must be at least 2");
      end
      if (SKIP_STYLE != 0 && SKIP_STYLE != 1) begin : g_bad_style
         $error("opx_exec: SKIP_STYLE must be 0 or 1");
      end
   endgenerate

   opx_ctl_t          ctl;
   logic [DATA_W-1:0] g1_ac, nxt_ac;
   logic              g1_lk, nxt_lk, cond_take, nxt_skip;
   logic [ADDR_W-1:0] nxt_pc;

   opx_decode u_dec (.instr(instr), .ctl(ctl));

   opx_group1 #(.DATA_W(DATA_W)) u_g1 (
      .clr_ac(ctl.clr_ac), .clr_lk(ctl.clr_lk),
      .cmp_ac(ctl.cmp_ac), .cmp_lk(ctl.cmp_lk),
      .inc_ac(ctl.inc_ac),
      .ac_i(ac_in), .lk_i(link_in),
      .ac_o(g1_ac), .lk_o(g1_lk)
   );

   opx_skip #(.DATA_W(DATA_W), .STYLE(SKIP_STYLE)) u_sk (
      .code(ctl.code), .ac(ac_in), .take(cond_take)
   );

   always_comb begin
      nxt_ac   = ac_in;
      nxt_lk   = link_in;
      nxt_skip = 1'b0;
      if (ctl.is_opr) begin
         if (ctl.grp2) begin
            nxt_skip = cond_take;
         end else begin
            nxt_ac = g1_ac;
            nxt_lk = g1_lk;
         end
      end
      nxt_pc = pc_in + (nxt_skip ? PC_TWO : PC_ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_out    <= '0;
         link_out  <= 1'b0;
         skip_out  <= 1'b0;
         pc_out    <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= exec_en;
         if (exec_en) begin
            ac_out   <= nxt_ac;
            link_out <= nxt_lk;
            skip_out <= nxt_skip;
            pc_out   <= nxt_pc;
         end
      end
   end

   // checks beside the state they guard
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en |=> res_valid);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> (!res_valid && $stable(ac_out) && $stable(link_out)
                    && $stable(pc_out) && $stable(skip_out)));
   assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en |=> ((pc_out - $past(pc_in)) == (skip_out ? PC_TWO : PC_ONE)));
   assert_nonopr_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr[OP_HI:OP_LO] != OPR_OPCODE) |=>
         (!skip_out && ac_out == $past(ac_in) && link_out == $past(link_in)));
   assert_g1_noskip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr[OP_HI:OP_LO] == OPR_OPCODE && !instr[GRP_BIT]) |=> !skip_out);
   assert_g2_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr[OP_HI:OP_LO] == OPR_OPCODE && instr[GRP_BIT]) |=>
         (ac_out == $past(ac_in) && link_out == $past(link_in)));
   assert_never_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && instr[OP_HI:OP_LO] == OPR_OPCODE && instr[GRP_BIT]
       && instr[SKC1_BIT] == 1'b0 && instr[SKC2_BIT] == 1'b0) |=>
         (skip_out == $past(instr[SKC0_BIT])));
endmodule

// File: tb/sim_opx_exec.sv
module sim_opx_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] ac_in = '0;
   logic        link_in = 1'b0;
   logic [11:0] pc_in = '0;
   logic [11:0] ac_out, pc_out;
   logic        link_out, skip_out, res_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   opx_exec u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
      .ac_in(ac_in), .link_in(link_in), .pc_in(pc_in),
      .ac_out(ac_out), .link_out(link_out), .skip_out(skip_out),
      .pc_out(pc_out), .res_valid(res_valid)
   );

   // {instr, ac, link, pc, exp_ac, exp_link, exp_skip, exp_pc}
   localparam int NV = 29;
   localparam logic [62:0] VEC [NV] = '{
      {12'hE40, 12'h123, 1'b1, 12'h010, 12'h123, 1'b0, 1'b0, 12'h011}, // R4 clear link
      {12'hE10, 12'h123, 1'b0, 12'h7FF, 12'h123, 1'b1, 1'b0, 12'h800}, // R4 complement link
      {12'hE50, 12'h000, 1'b0, 12'h000, 12'h000, 1'b1, 1'b0, 12'h001}, // R4 set link
      {12'hE80, 12'hABC, 1'b1, 12'h020, 12'h000, 1'b1, 1'b0, 12'h021}, // R5 clear AC
      {12'hE20, 12'h0F0, 1'b0, 12'h030, 12'hF0F, 1'b0, 1'b0, 12'h031}, // R5 complement AC
      {12'hEA0, 12'h555, 1'b0, 12'h040, 12'hFFF, 1'b0, 1'b0, 12'h041}, // R5 order
      {12'hE01, 12'h0FF, 1'b0, 12'h050, 12'h100, 1'b0, 1'b0, 12'h051}, // R6 inc
      {12'hE01, 12'hFFF, 1'b0, 12'h060, 12'h000, 1'b1, 1'b0, 12'h061}, // R6 carry
      {12'hE51, 12'hFFF, 1'b0, 12'h070, 12'h000, 1'b0, 1'b0, 12'h071}, // R6 set then carry
      {12'hEA1, 12'h123, 1'b1, 12'h080, 12'h000, 1'b0, 1'b0, 12'h081}, // R6 ones+1
      {12'hE21, 12'h005, 1'b0, 12'h090, 12'hFFB, 1'b0, 1'b0, 12'h091}, // R6 negate
      {12'hF00, 12'h000, 1'b1, 12'h100, 12'h000, 1'b1, 1'b0, 12'h101}, // R9 never
      {12'hF08, 12'h7FF, 1'b0, 12'hFFE, 12'h7FF, 1'b0, 1'b1, 12'h000}, // R9 always, R11 wrap
      {12'hF20, 12'h000, 1'b0, 12'h100, 12'h000, 1'b0, 1'b1, 12'h102}, // R9 =0
      {12'hF20, 12'h001, 1'b0, 12'h100, 12'h001, 1'b0, 1'b0, 12'h101}, // R9 =0 miss
      {12'hF28, 12'h800, 1'b0, 12'h100, 12'h800, 1'b0, 1'b1, 12'h102}, // R9 !=0
      {12'hF28, 12'h000, 1'b0, 12'h100, 12'h000, 1'b0, 1'b0, 12'h101}, // R9 !=0 miss
      {12'hF40, 12'h800, 1'b0, 12'h100, 12'h800, 1'b0, 1'b1, 12'h102}, // R10 <0
      {12'hF40, 12'h7FF, 1'b0, 12'h100, 12'h7FF, 1'b0, 1'b0, 12'h101}, // R10 <0 miss
      {12'hF48, 12'h7FF, 1'b0, 12'h100, 12'h7FF, 1'b0, 1'b1, 12'h102}, // R10 >0
      {12'hF48, 12'h000, 1'b0, 12'h100, 12'h000, 1'b0, 1'b0, 12'h101}, // R9 >0 miss
      {12'hF60, 12'h000, 1'b0, 12'h100, 12'h000, 1'b0, 1'b1, 12'h102}, // R9 <=0
      {12'hF60, 12'h001, 1'b0, 12'h100, 12'h001, 1'b0, 1'b0, 12'h101}, // R9 <=0 miss
      {12'hF68, 12'h000, 1'b0, 12'h100, 12'h000, 1'b0, 1'b1, 12'h102}, // R9 >=0
      {12'hF68, 12'hFFF, 1'b0, 12'h100, 12'hFFF, 1'b0, 1'b0, 12'h101}, // R10 >=0 miss
      {12'hF60, 12'hFFF, 1'b1, 12'h100, 12'hFFF, 1'b1, 1'b1, 12'h102}, // R10 <=0 neg
      {12'h240, 12'h3C3, 1'b1, 12'h055, 12'h3C3, 1'b1, 1'b0, 12'h056}, // R3 non-operate
      {12'hFBF, 12'h00F, 1'b1, 12'h200, 12'h00F, 1'b1, 1'b1, 12'h202}, // R8 extra bits
      {12'hE00, 12'h456, 1'b1, 12'h300, 12'h456, 1'b1, 1'b0, 12'h301}  // R7 empty group 1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input logic [62:0] v, input int idx);
      @(negedge clk);
      instr   = v[62:51];
      ac_in   = v[50:39];
      link_in = v[38];
      pc_in   = v[37:26];
      exec_en = 1'b1;
      @(negedge clk);
      exec_en = 1'b0;
      chk($sformatf("R2 valid v%0d", idx), {31'd0, res_valid}, 32'd1);
      chk($sformatf("R4-R6/R8 ac v%0d", idx), {20'd0, ac_out}, {20'd0, v[25:14]});
      chk($sformatf("R4/R6 link v%0d", idx), {31'd0, link_out}, {31'd0, v[13]});
      chk($sformatf("R9 skip v%0d", idx), {31'd0, skip_out}, {31'd0, v[12]});
      chk($sformatf("R11 pc v%0d", idx), {20'd0, pc_out}, {20'd0, v[11:0]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ac", {20'd0, ac_out}, 32'd0);
      chk("R1 link", {31'd0, link_out}, 32'd0);
      chk("R1 skip", {31'd0, skip_out}, 32'd0);
      chk("R1 pc", {20'd0, pc_out}, 32'd0);
      chk("R1 valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R2: idle cycles hold the last result
      @(negedge clk);
      instr = 12'hE80; ac_in = 12'h777; link_in = 1'b0; pc_in = 12'h400;
      @(negedge clk);
      chk("R2 idle valid", {31'd0, res_valid}, 32'd0);
      chk("R2 idle ac", {20'd0, ac_out}, 32'h456);
      chk("R2 idle link", {31'd0, link_out}, 32'd1);
      chk("R2 idle pc", {20'd0, pc_out}, 32'h301);

      // R3: opcode 6 with bits that look like group 2 codes
      run_vec({12'hD68, 12'h800, 1'b0, 12'hFFF, 12'h800, 1'b0, 1'b0, 12'h000}, 100);

      // R1: reset again after activity
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 re-reset ac", {20'd0, ac_out}, 32'd0);
      chk("R1 re-reset pc", {20'd0, pc_out}, 32'd0);
      chk("R1 re-reset valid", {31'd0, res_valid}, 32'd0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule